// File: doc/BRIEF.md
# Programmable External Memory Access Controller

This block gives a co-processor a set of indirect windows onto external memory. Software first sets a shared control register with two 16-bit words, an address and then a mode word. It then makes a "blind" read or write of one of the port registers, which copies that address and mode into the port's read slot or write slot. After that, each read or write of the port runs one external memory cycle at the slot's current address, and the slot address then moves on as the mode selects. The co-processor can step through data memory with a fixed stride, walk a cell-arranged pattern, merge nibbles into existing words, or fetch from ROM with an extended address.

Co-processor accesses are single-cycle. Read data comes back through `cp_rdata` in the same cycle, either from the control register, from external memory (which answers combinationally) or from the port's own plain register. Two bank-enable inputs gate ports 0 to 3. Port 4 always uses its slots.

Top module: `extmem_port_ctl`

## Requirements
- R1: After reset, the control register's address is 0x0000, it waits for an address, it is not armed, and no port has a programmed slot. A read of any port returns its plain register value (0x0000) with no memory cycle.
- R2: A control write in the waiting-for-address state stores the address and moves to waiting-for-mode. A control write in the waiting-for-mode state stores the mode, arms the block and moves back to waiting-for-address.
- R3: A control read also advances the state. In waiting-for-address it returns the stored address. In waiting-for-mode it returns the address rotated left by one nibble (bits 11:0 move to bits 15:4, and bits 15:12 move to bits 3:0), and it arms the block.
- R4: While armed, the next port access copies the control address and mode into that port's read slot (on a read) or write slot (on a write). It then disarms. This access makes no memory cycle and discards its write data.
- R5: For data-memory modes, mode bits 13:11 choose the step after each access: 0 gives no step, and 1 to 7 give steps of 1, 2, 4, 8, 16, 32 and 128. Mode bit 15 set makes the step negative. Data-memory modes have mode bits 9:0 equal to 0x018 and mode bit 14 equal to 0. The external address is the 16-bit slot address with the top four bits 0.
- R6: A write with mode bit 10 set drives nibble enable i high only when written nibble i (bits 4i+3:4i) is non-zero. Other writes enable all four nibbles. Reads drive all nibble enables low.
- R7: A write mode with bits 15:11 equal to 0b01000 and bits 9:0 equal to 0x018 is cell mode. After each access the address moves by 31 if it was odd and by 1 if it was even.
- R8: A read slot whose mode bits 15:4 equal 0x080 reads ROM (`mem_rom` high). The external address is {mode[3:0], address}, and the address always steps by 1. A ROM cycle never writes.
- R9: After each memory access, the control register's address and mode take the accessed slot's values, after the step.
- R10: Ports 0 to 3 use their programmed slots only when `bank_en` is non-zero. Port 4 uses its slots whatever `bank_en` is.
- R11: A port access that is not programming a slot and cannot use a slot makes no memory cycle. This covers a slot that is not programmed, a gated port, and a mode that is none of the above. Such an access writes or reads the port's plain register.
- R12: Any port access made while the control register waits for a mode sends it back to waiting-for-address, without storing a mode or arming the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cp_rd | input | 1 | Co-processor read strobe |
| cp_wr | input | 1 | Co-processor write strobe (takes priority over cp_rd) |
| cp_ctl | input | 1 | 1 selects the control register, 0 selects a port |
| cp_port | input | PORT_W (3) | Port number 0 to 4 |
| cp_wdata | input | 16 | Co-processor write data |
| cp_rdata | output | 16 | Co-processor read data |
| bank_en | input | 2 | Bank-enable bits that gate ports 0 to 3 |
| mem_req | output | 1 | External memory cycle this clock |
| mem_we | output | 1 | External cycle is a write |
| mem_rom | output | 1 | External cycle targets ROM |
| mem_addr | output | 20 | External word address |
| mem_wdata | output | 16 | External write data |
| mem_nib_en | output | 4 | Per-nibble write enables |
| mem_rdata | input | 16 | External read data, valid in the same cycle |

## Verification
The bench walks the two-phase programming sequence, including control reads that arm the block and the rotated address they return. A design that did not advance on reads would program ports with stale modes, and every later address would be wrong. It checks the step sizes (including the irregular 128 and a negative stride) and the odd/even cell step. A decoder off by one in the step table or in the parity test shows up as a wrong `mem_addr` on the second access. Nibble merging is checked by reading the merged word back. The bench also returns a port access to waiting-for-address after only the address was written; a design that kept waiting for a mode would store the next address as a mode and arm early. Gated ports, unsupported modes and ports reset to no slot must fall back to the plain register with `mem_req` low.

// File: rtl/extmem_pkg.sv
package extmem_pkg;

   localparam int WORD_W = 16;

   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_ROM  = 2'd1,
      ACC_DATA = 2'd2,
      ACC_CELL = 2'd3
   } acc_kind_e;

   typedef struct packed {
      logic [WORD_W-1:0] mode;
      logic [WORD_W-1:0] addr;
   } slot_t;

   // step magnitude for the 3-bit step field: 0,1,2,4,8,16,32,128
   function automatic logic [WORD_W-1:0] step_size(input logic [2:0] code);
      logic [WORD_W-1:0] s;
      if (code == 3'd0)
         s = '0;
      else if (code == 3'd7)
         s = WORD_W'(128);
      else
         s = WORD_W'(1) << (code - 3'd1);
      return s;
   endfunction

endpackage

// File: rtl/extmem_decode.sv
module extmem_decode
   import extmem_pkg::*;
#(
   parameter int ROM_HI_W     = 4,
   parameter bit OVERWRITE_EN = 1'b1,
   localparam int NIB_N       = WORD_W / 4,
   localparam int EXT_W       = WORD_W + ROM_HI_W
) (
   input  slot_t             slot,
   input  logic              is_wr,
   input  logic [WORD_W-1:0] wdata,
   output acc_kind_e         kind,
   output logic [WORD_W-1:0] next_addr,
   output logic [EXT_W-1:0]  ext_addr,
   output logic [NIB_N-1:0]  nib_en
);

   logic          tgt_data;
   logic          dir_neg;
   logic [WORD_W-1:0] stride;

   assign tgt_data = (slot.mode[9:0] == 10'h018);
   assign dir_neg  = slot.mode[15];
   assign stride   = step_size(slot.mode[13:11]);

   always_comb begin
      kind = ACC_NONE;
      if (!is_wr && slot.mode[15:4] == 12'h080)
         kind = ACC_ROM;
      else if (tgt_data && !slot.mode[14])
         kind = ACC_DATA;
      else if (is_wr && tgt_data && slot.mode[15:11] == 5'b01000)
         kind = ACC_CELL;
   end

   always_comb begin
      unique case (kind)
         ACC_ROM:  next_addr = slot.addr + WORD_W'(1);
         ACC_CELL: next_addr = slot.addr + (slot.addr[0] ? WORD_W'(31) : WORD_W'(1));
         ACC_DATA: next_addr = dir_neg ? (slot.addr - stride) : (slot.addr + stride);
         default:  next_addr = slot.addr;
      endcase
   end

   always_comb begin
      if (kind == ACC_ROM)
         ext_addr = {slot.mode[ROM_HI_W-1:0], slot.addr};
      else
         ext_addr = {{ROM_HI_W{1'b0}}, slot.addr};
   end

   generate
      if (OVERWRITE_EN) begin : g_ovw
         for (genvar n = 0; n < NIB_N; n++) begin : g_nib
            always_comb begin
               if (!is_wr)
                  nib_en[n] = 1'b0;
               else if (slot.mode[10])
                  nib_en[n] = |wdata[4*n +: 4];
               else
                  nib_en[n] = 1'b1;
            end
         end
      end else begin : g_full
         assign nib_en = is_wr ? {NIB_N{1'b1}} : {NIB_N{1'b0}};
      end
   endgenerate

endmodule

// File: rtl/extmem_ctl.sv
module extmem_ctl
   import extmem_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic              ctl_rd,
   input  logic              port_hit,
   input  logic              reload,
   input  slot_t             reload_slot,
   input  logic [WORD_W-1:0] wdata,
   output slot_t             view,
   output logic              armed,
   output logic              await_mode,
   output logic [WORD_W-1:0] rdata
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         view       <= '0;
         armed      <= 1'b0;
         await_mode <= 1'b0;
      end else if (ctl_wr) begin
         if (!await_mode) begin
            view.addr  <= wdata;
            await_mode <= 1'b1;
         end else begin
            view.mode  <= wdata;
            await_mode <= 1'b0;
            armed      <= 1'b1;
         end
      end else if (ctl_rd) begin
         if (await_mode) begin
            await_mode <= 1'b0;
            armed      <= 1'b1;
         end else begin
            await_mode <= 1'b1;
         end
      end else if (port_hit) begin
         await_mode <= 1'b0;
         armed      <= 1'b0;
         if (reload)
            view <= reload_slot;
      end
   end

   assign rdata = await_mode ? {view.addr[WORD_W-5:0], view.addr[WORD_W-1:WORD_W-4]}
                             : view.addr;

endmodule

// File: rtl/extmem_slot.sv
module extmem_slot
   import extmem_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_rd,
   input  logic              prog_wr,
   input  slot_t             prog_val,
   input  logic              adv_rd,
   input  logic              adv_wr,
   input  logic [WORD_W-1:0] adv_addr,
   input  logic              plain_we,
   input  logic [WORD_W-1:0] wdata,
   output slot_t             rd_slot,
   output slot_t             wr_slot,
   output logic              rd_ok,
   output logic              wr_ok,
   output logic [WORD_W-1:0] plain
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_slot <= '0;
         rd_ok   <= 1'b0;
      end else if (prog_rd) begin
         rd_slot <= prog_val;
         rd_ok   <= 1'b1;
      end else if (adv_rd) begin
         rd_slot.addr <= adv_addr;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_slot <= '0;
         wr_ok   <= 1'b0;
      end else if (prog_wr) begin
         wr_slot <= prog_val;
         wr_ok   <= 1'b1;
      end else if (adv_wr) begin
         wr_slot.addr <= adv_addr;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         plain <= '0;
      else if (plain_we)
         plain <= wdata;
   end

endmodule

// File: rtl/extmem_port_ctl.sv
module extmem_port_ctl
   import extmem_pkg::*;
#(
   parameter int           N_PORTS      = 5,
   parameter int           PORT_W       = $clog2(N_PORTS),
   parameter int           ROM_HI_W     = 4,
   parameter bit           OVERWRITE_EN = 1'b1,
   parameter logic [N_PORTS-1:0] ALWAYS_MASK = 5'b10000,
   localparam int          NIB_N        = WORD_W / 4,
   localparam int          EXT_W        = WORD_W + ROM_HI_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cp_rd,
   input  logic              cp_wr,
   input  logic              cp_ctl,
   input  logic [PORT_W-1:0] cp_port,
   input  logic [WORD_W-1:0] cp_wdata,
   output logic [WORD_W-1:0] cp_rdata,
   input  logic [1:0]        bank_en,
   output logic              mem_req,
   output logic              mem_we,
   output logic              mem_rom,
   output logic [EXT_W-1:0]  mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   output logic [NIB_N-1:0]  mem_nib_en,
   input  logic [WORD_W-1:0] mem_rdata
);

   if (N_PORTS < 1 || N_PORTS > (1 << PORT_W)) begin : g_bad_ports
      $error("extmem_port_ctl: N_PORTS does not fit PORT_W");
   end
   if (ROM_HI_W < 1 || ROM_HI_W > 4) begin : g_bad_rom
      $error("extmem_port_ctl: ROM_HI_W must be 1..4");
   end

   // ---- access decode ----
   logic is_wr, port_acc, ctl_wr, ctl_rd;
   assign is_wr    = cp_wr;
   assign port_acc = (cp_rd | cp_wr) & ~cp_ctl & (32'(cp_port) < N_PORTS);
   assign ctl_wr   = cp_wr & cp_ctl;
   assign ctl_rd   = cp_rd & ~cp_wr & cp_ctl;

   // ---- control register ----
   slot_t             view;
   logic              armed, await_mode;
   logic [WORD_W-1:0] ctl_rdata;
   logic              use_mem;
   slot_t             reload_val;

   extmem_ctl u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctl_wr      (ctl_wr),
      .ctl_rd      (ctl_rd),
      .port_hit    (port_acc),
      .reload      (use_mem),
      .reload_slot (reload_val),
      .wdata       (cp_wdata),
      .view        (view),
      .armed       (armed),
      .await_mode  (await_mode),
      .rdata       (ctl_rdata)
   );

   // ---- per-port slots ----
   slot_t             rd_slot [N_PORTS];
   slot_t             wr_slot [N_PORTS];
   logic [N_PORTS-1:0] rd_ok, wr_ok, hit;
   logic [WORD_W-1:0] plain [N_PORTS];
   logic              programming, plain_acc;
   logic [WORD_W-1:0] next_addr;

   assign programming = port_acc & armed;

   generate
      for (genvar p = 0; p < N_PORTS; p++) begin : g_port
         assign hit[p] = port_acc & (cp_port == PORT_W'(p));
         extmem_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .prog_rd  (hit[p] & programming & ~is_wr),
            .prog_wr  (hit[p] & programming & is_wr),
            .prog_val (view),
            .adv_rd   (hit[p] & use_mem & ~is_wr),
            .adv_wr   (hit[p] & use_mem & is_wr),
            .adv_addr (next_addr),
            .plain_we (hit[p] & plain_acc & is_wr),
            .wdata    (cp_wdata),
            .rd_slot  (rd_slot[p]),
            .wr_slot  (wr_slot[p]),
            .rd_ok    (rd_ok[p]),
            .wr_ok    (wr_ok[p]),
            .plain    (plain[p])
         );
      end
   endgenerate

   // ---- selected port ----
   slot_t             cur_slot;
   logic              cur_ok, gate_ok;
   logic [WORD_W-1:0] cur_plain;

   always_comb begin
      cur_slot  = '0;
      cur_ok    = 1'b0;
      gate_ok   = 1'b0;
      cur_plain = '0;
      for (int i = 0; i < N_PORTS; i++) begin
         if (hit[i]) begin
            cur_slot  = is_wr ? wr_slot[i] : rd_slot[i];
            cur_ok    = is_wr ? wr_ok[i] : rd_ok[i];
            gate_ok   = ALWAYS_MASK[i] | (|bank_en);
            cur_plain = plain[i];
         end
      end
   end

   // ---- address/mode decode ----
   acc_kind_e        kind;
   logic [EXT_W-1:0] ext_addr;
   logic [NIB_N-1:0] nib_en;

   extmem_decode #(
      .ROM_HI_W     (ROM_HI_W),
      .OVERWRITE_EN (OVERWRITE_EN)
   ) u_dec (
      .slot      (cur_slot),
      .is_wr     (is_wr),
      .wdata     (cp_wdata),
      .kind      (kind),
      .next_addr (next_addr),
      .ext_addr  (ext_addr),
      .nib_en    (nib_en)
   );

   assign use_mem    = port_acc & ~armed & gate_ok & cur_ok & (kind != ACC_NONE);
   assign plain_acc  = port_acc & ~armed & ~use_mem;
   assign reload_val = '{mode: cur_slot.mode, addr: next_addr};

   // ---- external memory request ----
   assign mem_req    = use_mem;
   assign mem_we     = use_mem & is_wr;
   assign mem_rom    = use_mem & (kind == ACC_ROM);
   assign mem_addr   = use_mem ? ext_addr : '0;
   assign mem_wdata  = (use_mem & is_wr) ? cp_wdata : '0;
   assign mem_nib_en = use_mem ? nib_en : '0;

   // ---- read return ----
   always_comb begin
      if (ctl_rd)
         cp_rdata = ctl_rdata;
      else if (port_acc & ~is_wr & use_mem)
         cp_rdata = mem_rdata;
      else if (port_acc & ~is_wr)
         cp_rdata = cur_plain;
      else
         cp_rdata = '0;
   end

endmodule

// File: rtl/extmem_port_ctl_chk.sv
module extmem_port_ctl_chk #(
   parameter int N_PORTS = 5,
   parameter int PORT_W  = 3,
   parameter logic [N_PORTS-1:0] ALWAYS_MASK = 5'b10000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cp_rd,
   input logic              cp_wr,
   input logic              cp_ctl,
   input logic [PORT_W-1:0] cp_port,
   input logic [1:0]        bank_en,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_rom,
   input logic [3:0]        mem_nib_en,
   input logic              armed,
   input logic              await_mode
);

   logic pacc;
   assign pacc = (cp_rd | cp_wr) & ~cp_ctl & (32'(cp_port) < N_PORTS);

   // R4
   prog_no_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && pacc) |-> !mem_req);

   // R4
   prog_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && pacc) |=> !armed);

   // R2
   mode_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_wr && cp_ctl && await_mode) |=> (armed && !await_mode));

   // R12
   port_clears_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pacc |=> !await_mode);

   // R8
   rom_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_rom) |-> !mem_we);

   // R11
   req_needs_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> pacc);

   // R10
   gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !ALWAYS_MASK[cp_port]) |-> (bank_en != 2'b00));

   // R6
   read_nib_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> (mem_nib_en == 4'h0));

endmodule

bind extmem_port_ctl extmem_port_ctl_chk #(
   .N_PORTS     (N_PORTS),
   .PORT_W      (PORT_W),
   .ALWAYS_MASK (ALWAYS_MASK)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cp_rd      (cp_rd),
   .cp_wr      (cp_wr),
   .cp_ctl     (cp_ctl),
   .cp_port    (cp_port),
   .bank_en    (bank_en),
   .mem_req    (mem_req),
   .mem_we     (mem_we),
   .mem_rom    (mem_rom),
   .mem_nib_en (mem_nib_en),
   .armed      (armed),
   .await_mode (await_mode)
);

// File: tb/extmem_port_ctl_test.sv
module extmem_port_ctl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cp_rd = 1'b0, cp_wr = 1'b0, cp_ctl = 1'b0;
   logic [2:0]  cp_port = '0;
   logic [15:0] cp_wdata = '0;
   logic [15:0] cp_rdata;
   logic [1:0]  bank_en = '0;
   logic        mem_req, mem_we, mem_rom;
   logic [19:0] mem_addr;
   logic [15:0] mem_wdata, mem_rdata;
   logic [3:0]  mem_nib_en;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   extmem_port_ctl uut (
      .clk(clk), .rst_n(rst_n), .cp_rd(cp_rd), .cp_wr(cp_wr), .cp_ctl(cp_ctl),
      .cp_port(cp_port), .cp_wdata(cp_wdata), .cp_rdata(cp_rdata), .bank_en(bank_en),
      .mem_req(mem_req), .mem_we(mem_we), .mem_rom(mem_rom), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_nib_en(mem_nib_en), .mem_rdata(mem_rdata)
   );

   // external memory model: 256-word data RAM, computed ROM
   logic [15:0] dram [256];
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) dram[i] <= '0;
      end else if (mem_req && mem_we) begin
         for (int n = 0; n < 4; n++)
            if (mem_nib_en[n]) dram[mem_addr[7:0]][4*n +: 4] <= mem_wdata[4*n +: 4];
      end
   end
   assign mem_rdata = mem_rom ? (mem_addr[15:0] ^ 16'hC3A5) : dram[mem_addr[7:0]];

   typedef struct packed {
      logic [1:0]  op;     // 1 read, 2 write
      logic        ctl;
      logic [2:0]  port;
      logic [15:0] wd;
      logic [1:0]  en;
      logic        chk;
      logic [15:0] exp_rd;
      logic        req;
      logic        rom;
      logic [19:0] addr;
      logic [3:0]  nib;
      logic [3:0]  tag;
   } vec_t;

   function automatic vec_t cw(input logic [15:0] d);
      return '{op:2'd2, ctl:1'b1, port:3'd0, wd:d, en:2'd0, chk:1'b0, exp_rd:16'h0,
               req:1'b0, rom:1'b0, addr:20'h0, nib:4'h0, tag:4'd2};
   endfunction
   function automatic vec_t cr(input logic [15:0] e, input logic [3:0] t);
      return '{op:2'd1, ctl:1'b1, port:3'd0, wd:16'h0, en:2'd0, chk:1'b1, exp_rd:e,
               req:1'b0, rom:1'b0, addr:20'h0, nib:4'h0, tag:t};
   endfunction
   function automatic vec_t pw(input logic [2:0] p, input logic [15:0] d, input logic [1:0] e,
                               input logic q, input logic [19:0] a, input logic [3:0] n,
                               input logic [3:0] t);
      return '{op:2'd2, ctl:1'b0, port:p, wd:d, en:e, chk:1'b0, exp_rd:16'h0,
               req:q, rom:1'b0, addr:a, nib:n, tag:t};
   endfunction
   function automatic vec_t pr(input logic [2:0] p, input logic [1:0] e, input logic [15:0] x,
                               input logic q, input logic r, input logic [19:0] a,
                               input logic [3:0] t);
      return '{op:2'd1, ctl:1'b0, port:p, wd:16'h0, en:e, chk:1'b1, exp_rd:x,
               req:q, rom:r, addr:a, nib:4'h0, tag:t};
   endfunction

   localparam int NV = 56;
   localparam vec_t TBL [NV] = '{
      cw(16'h0010), cw(16'h0818),                                      // R2
      pw(3'd4, 16'h0000, 2'd0, 1'b0, 20'h0, 4'h0, 4'd4),               // R4 blind
      pw(3'd4, 16'h1234, 2'd0, 1'b1, 20'h00010, 4'hF, 4'd10),          // R10 port 4 ungated
      pw(3'd4, 16'hABCD, 2'd0, 1'b1, 20'h00011, 4'hF, 4'd5),           // R5 step 1
      cr(16'h0012, 4'd9),                                              // R9
      cr(16'h0120, 4'd3),                                              // R3 rotate, arm
      pw(3'd3, 16'h0000, 2'd1, 1'b0, 20'h0, 4'h0, 4'd4),               // R4
      pw(3'd3, 16'h5A5A, 2'd1, 1'b1, 20'h00012, 4'hF, 4'd4),           // R4 slot from read-arm
      cw(16'h0010), cw(16'h0818),
      pr(3'd4, 2'd0, 16'h0000, 1'b0, 1'b0, 20'h0, 4'd4),               // R4 blind read
      pr(3'd4, 2'd0, 16'h1234, 1'b1, 1'b0, 20'h00010, 4'd5),           // R5
      pr(3'd4, 2'd0, 16'hABCD, 1'b1, 1'b0, 20'h00011, 4'd5),
      pr(3'd4, 2'd0, 16'h5A5A, 1'b1, 1'b0, 20'h00012, 4'd5),
      cw(16'h0010), cw(16'h0418),
      pw(3'd3, 16'h0000, 2'd1, 1'b0, 20'h0, 4'h0, 4'd4),
      pw(3'd3, 16'h0F00, 2'd1, 1'b1, 20'h00010, 4'h4, 4'd6),           // R6 overwrite
      pw(3'd3, 16'h7777, 2'd0, 1'b0, 20'h0, 4'h0, 4'd10),              // R10 gated
      pr(3'd3, 2'd0, 16'h7777, 1'b0, 1'b0, 20'h0, 4'd11),              // R11 plain
      cw(16'h0010), cw(16'h0018),
      pr(3'd0, 2'd1, 16'h0000, 1'b0, 1'b0, 20'h0, 4'd4),
      pr(3'd0, 2'd1, 16'h1F34, 1'b1, 1'b0, 20'h00010, 4'd6),           // R6 merged word
      cw(16'h0030), cw(16'h9818),
      pw(3'd0, 16'h0000, 2'd1, 1'b0, 20'h0, 4'h0, 4'd4),
      pw(3'd0, 16'h1111, 2'd1, 1'b1, 20'h00030, 4'hF, 4'd5),
      pw(3'd0, 16'h2222, 2'd1, 1'b1, 20'h0002C, 4'hF, 4'd5),           // R5 negative 4
      cw(16'h0041), cw(16'h4018),
      pw(3'd1, 16'h0000, 2'd2, 1'b0, 20'h0, 4'h0, 4'd4),
      pw(3'd1, 16'h3333, 2'd2, 1'b1, 20'h00041, 4'hF, 4'd7),           // R7
      pw(3'd1, 16'h4444, 2'd2, 1'b1, 20'h00060, 4'hF, 4'd7),           // R7 odd +31
      cr(16'h0061, 4'd9),                                              // R9 cell even +1
      pr(3'd3, 2'd0, 16'h7777, 1'b0, 1'b0, 20'h0, 4'd12),              // R12
      cw(16'h0123),
      cr(16'h1230, 4'd12),                                             // R12 stored as address
      pw(3'd3, 16'h0000, 2'd0, 1'b0, 20'h0, 4'h0, 4'd4),
      cw(16'h1234), cw(16'h0803),
      pr(3'd2, 2'd1, 16'h0000, 1'b0, 1'b0, 20'h0, 4'd4),
      pr(3'd2, 2'd1, 16'hD191, 1'b1, 1'b1, 20'h31234, 4'd8),           // R8
      pr(3'd2, 2'd1, 16'hD190, 1'b1, 1'b1, 20'h31235, 4'd8),
      cr(16'h1236, 4'd9),                                              // R9 after ROM
      pr(3'd3, 2'd0, 16'h7777, 1'b0, 1'b0, 20'h0, 4'd12),
      cw(16'h0005), cw(16'h3818),
      pw(3'd4, 16'h0000, 2'd0, 1'b0, 20'h0, 4'h0, 4'd4),
      pw(3'd4, 16'hBEEF, 2'd0, 1'b1, 20'h00005, 4'hF, 4'd5),
      pw(3'd4, 16'hCAFE, 2'd0, 1'b1, 20'h00085, 4'hF, 4'd5),           // R5 step 128
      cw(16'h0100), cw(16'h0003),
      pw(3'd4, 16'h0000, 2'd0, 1'b0, 20'h0, 4'h0, 4'd4),
      pw(3'd4, 16'h9999, 2'd0, 1'b0, 20'h0, 4'h0, 4'd11)               // R11 unsupported mode
   };

   task automatic check(input bit ok, input int tag, input string what,
                        input logic [19:0] act, input logic [19:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL R%0d %s actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic idle();
      cp_rd = 1'b0; cp_wr = 1'b0; cp_ctl = 1'b0;
   endtask

   task automatic apply(input vec_t v, input int idx);
      @(negedge clk);
      cp_rd    = (v.op == 2'd1);
      cp_wr    = (v.op == 2'd2);
      cp_ctl   = v.ctl;
      cp_port  = v.port;
      cp_wdata = v.wd;
      bank_en  = v.en;
      #4;
      check(mem_req == v.req, int'(v.tag), $sformatf("row %0d mem_req", idx),
            20'(mem_req), 20'(v.req));
      if (v.chk)
         check(cp_rdata == v.exp_rd, int'(v.tag), $sformatf("row %0d cp_rdata", idx),
               20'(cp_rdata), 20'(v.exp_rd));
      if (v.req) begin
         check(mem_addr == v.addr, int'(v.tag), $sformatf("row %0d mem_addr", idx),
               mem_addr, v.addr);
         check(mem_rom == v.rom, int'(v.tag), $sformatf("row %0d mem_rom", idx),
               20'(mem_rom), 20'(v.rom));
         check(mem_we == (v.op == 2'd2), int'(v.tag), $sformatf("row %0d mem_we", idx),
               20'(mem_we), 20'(v.op == 2'd2));
         if (v.op == 2'd2)
            check(mem_nib_en == v.nib, int'(v.tag), $sformatf("row %0d mem_nib_en", idx),
                  20'(mem_nib_en), 20'(v.nib));
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog actual %0d expected below 20000", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      for (int i = 0; i < NV; i++) apply(TBL[i], i);
      @(negedge clk) idle();

      // directed: reset clears state and slots (R1)
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      #4;
      check(mem_req == 1'b0, 1, "idle mem_req after reset", 20'(mem_req), 20'h0);
      apply(cr(16'h0000, 4'd1), 100);                                   // R1 address 0
      apply(pr(3'd4, 2'd3, 16'h0000, 1'b0, 1'b0, 20'h0, 4'd1), 101);  // R1 no slot
      // R11: fallback plain register on port 4 after reset
      apply(pw(3'd4, 16'h4242, 2'd0, 1'b0, 20'h0, 4'h0, 4'd11), 102);
      apply(pr(3'd4, 2'd0, 16'h4242, 1'b0, 1'b0, 20'h0, 4'd11), 103);
      // R3: read in address state returns the address unrotated, then rotates
      apply(cw(16'hA5C3), 104);
      apply(cr(16'h5C3A, 4'd3), 105);
      apply(pr(3'd1, 2'd0, 16'h0000, 1'b0, 1'b0, 20'h0, 4'd4), 106);   // R4 disarm
      apply(cr(16'hA5C3, 4'd3), 107);
      @(negedge clk) idle();

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule